// File: doc/BRIEF.md
# Flash Command Register Controller

This block sits on the device side of a byte-wide flash part and turns bus write cycles into the modes that drive the storage array. It forms a single write strobe from the active-low chip-enable and write-enable inputs, brings it into the clock domain, and detects its edges. The address is taken when the strobe falls and the data when it rises. A mode machine then moves between array read, identifier read, erase and program setup, the erase and program pulses, and the two verify modes. A stop timer bounds each pulse.

Commands are honoured only while the high-voltage-present input is asserted. Without it the block is a plain read-only memory: writes are ignored, reads return array bytes, and the identifier bytes can be read through a hardware select input. The storage array is a behavioural byte memory. An erase sets every byte to FFh. A program clears bits only, so the new byte is the old byte ANDed with the written data. Either change takes effect in the cycle its pulse ends.

Command codes: 00h array read, 20h erase setup and erase confirm, A0h erase verify, 40h program setup, C0h program verify, 90h identifier read, FFh reset. The second program cycle carries the byte to be written and the address to write it to. The address and data must stay stable for three clock cycles after the strobe edge that captures them.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While `hv_on` is low, every write is ignored, the mode returns to array read on the next clock, and any running pulse stops without changing the array. With `hv_on` low and `id_sel` high, reads return the identifier bytes.
- R2: An erase pulse starts only after 20h is written twice in a row. A program pulse starts only after 40h is followed by a second write, whose data byte and address name the target.
- R3: The write address is captured when the combined strobe (`we_n` OR `ce_n`) falls, which happens when the later of the two inputs falls.
- R4: The write data is captured when the combined strobe rises, which happens when the earlier of the two inputs rises. Data changes after that point have no effect.
- R5: After reset the block is in array read mode, both pulses are off, and every array byte reads FFh.
- R6: Writing A0h during an erase ends the pulse and sets every byte to FFh. The block then shows the byte at the A0h write address, whatever address is presented for the read.
- R7: Writing C0h during a program pulse ends the pulse. The programmed byte becomes old AND data, and the block then shows the programmed byte whatever address is presented for the read.
- R8: Each pulse ends by itself after `ERASE_TICKS` (erase) or `PROG_TICKS` (program) cycles. A one-cycle timeout strobe marks this, and the array change is applied.
- R9: 90h selects identifier read. An even read address returns `MFG_ID` and an odd address returns `DEV_ID`. 00h returns to array read.
- R10: FFh takes effect only when written twice in a row, and then gives array read. A single FFh leaves the current mode unchanged.
- R11: An unrecognised byte, or a second erase cycle that is not 20h, returns the block to array read. No pulse starts and the array is unchanged.
- R12: `dq_oe` is high only while `ce_n` and `oe_n` are low and `we_n` is high.
- R13: The erase and program pulses are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| hv_on | input | 1 | High programming voltage is present |
| id_sel | input | 1 | Hardware identifier select, used while `hv_on` is low |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Write data bus |
| dq_out | output | 8 | Read data bus |
| dq_oe | output | 1 | Read data drive enable |
| erase_pulse | output | 1 | Erase pulse active |
| prog_pulse | output | 1 | Program pulse active |
| erase_tmo | output | 1 | One-cycle strobe when the erase stop timer expires |
| prog_tmo | output | 1 | One-cycle strobe when the program stop timer expires |

## Verification
A running pulse can end in the same cycle that the high-voltage input drops. In that cycle the stop timer sees a stop request while the array update is being decided. The bench starts an erase and a separate program pulse, then removes `hv_on` mid-pulse. It checks that the pulse output falls on the next clock and that the previously programmed bytes still read back unchanged, so the forced stop is not taken as a completed pulse. Random program traffic with interleaved unrecognised commands then checks the bit-clearing rule against a bench memory model.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    ST_READ,
    ST_IDENT,
    ST_ERS_ARM,
    ST_ERASING,
    ST_ERS_CHECK,
    ST_PRG_ARM,
    ST_PROGRAMMING,
    ST_PRG_CHECK
  } mode_e;

  localparam logic [7:0] OP_READ    = 8'h00;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_ERS_VFY = 8'hA0;
  localparam logic [7:0] OP_PROG    = 8'h40;
  localparam logic [7:0] OP_PRG_VFY = 8'hC0;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_RESET   = 8'hFF;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  // Programming can only clear bits of a cell.
  function automatic logic [7:0] prog_merge(input logic [7:0] old_b,
                                            input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  // Identifier byte chosen by the low address bit.
  function automatic logic [7:0] ident_byte(input logic sel_dev,
                                            input logic [7:0] mfg,
                                            input logic [7:0] dev);
    return sel_dev ? dev : mfg;
  endfunction

endpackage

// File: rtl/flash_wr_strobe.sv
module flash_wr_strobe #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [7:0]        cmd_data,
  output logic              cmd_vld
);

  logic strobe_n;
  logic s1, s2, s3;
  logic fall, rise;

  assign strobe_n = we_n | ce_n;
  assign fall     = s3 & ~s2;
  assign rise     = ~s3 & s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1       <= 1'b1;
      s2       <= 1'b1;
      s3       <= 1'b1;
      cmd_vld  <= 1'b0;
      lat_addr <= '0;
      cmd_data <= '0;
    end else begin
      s1      <= strobe_n;
      s2      <= s1;
      s3      <= s2;
      cmd_vld <= rise;
      if (fall) lat_addr <= addr;
      if (rise) cmd_data <= din;
    end
  end

  assert_addr_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> lat_addr == $past(addr));

  assert_data_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (cmd_vld && cmd_data == $past(din)));

endmodule

// File: rtl/flash_stop_timer.sv
module flash_stop_timer #(
  parameter int LIMIT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  output logic active,
  output logic fin,
  output logic tmo
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;
  logic          last;

  assign last = active && (cnt == CW'(LIMIT - 1));
  assign fin  = active && (stop || last);
  assign tmo  = last && !stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (fin) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_pulse_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> cnt < CW'(LIMIT));

  assert_tmo_ends_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !active);

endmodule

// File: rtl/flash_cell_model.sv
module flash_cell_model
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_all,
  input  logic              prog_en,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [7:0]        prog_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
    end else if (erase_all) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
    end else if (prog_en) begin
      mem[prog_addr] <= prog_merge(mem[prog_addr], prog_data);
    end
  end

  assign rd_data = mem[rd_addr];

  assert_one_array_op_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(erase_all && prog_en));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W      = 6,
  parameter int         ERASE_TICKS = 200,
  parameter int         PROG_TICKS  = 20,
  parameter logic [7:0] MFG_ID      = 8'h01,
  parameter logic [7:0] DEV_ID      = 8'hA1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              hv_on,
  input  logic              id_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  output logic              erase_pulse,
  output logic              prog_pulse,
  output logic              erase_tmo,
  output logic              prog_tmo
);

  // Named internal events, visible to the assertions below.
  logic [ADDR_W-1:0] lat_addr;
  logic [7:0]        cmd_data;
  logic              cmd_vld;
  logic              ers_start, ers_stop, ers_fin;
  logic              prg_start, prg_stop, prg_fin;
  logic              cap_ver, cap_prg;
  logic              erase_all, prog_en;

  mode_e             mode, nxt_mode, view_mode;
  logic              rst_armed, nxt_armed;
  logic [ADDR_W-1:0] ver_addr, prg_addr;
  logic [7:0]        prg_data;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;
  logic              id_view;

  flash_wr_strobe #(.ADDR_W(ADDR_W)) u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .addr     (addr),
    .din      (dq_in),
    .lat_addr (lat_addr),
    .cmd_data (cmd_data),
    .cmd_vld  (cmd_vld)
  );

  // Mode decoding
  always_comb begin
    nxt_mode  = mode;
    nxt_armed = rst_armed;
    ers_start = 1'b0;
    ers_stop  = 1'b0;
    prg_start = 1'b0;
    prg_stop  = 1'b0;
    cap_ver   = 1'b0;
    cap_prg   = 1'b0;
    if (!hv_on) begin
      nxt_mode  = ST_READ;
      nxt_armed = 1'b0;
    end else if (cmd_vld) begin
      nxt_armed = 1'b0;
      case (mode)
        ST_ERS_ARM: begin
          if (cmd_data == OP_ERASE) begin
            nxt_mode  = ST_ERASING;
            ers_start = 1'b1;
          end else begin
            nxt_mode = ST_READ;
          end
        end
        ST_PRG_ARM: begin
          nxt_mode  = ST_PROGRAMMING;
          prg_start = 1'b1;
          cap_prg   = 1'b1;
        end
        ST_ERASING: begin
          ers_stop = 1'b1;
          if (cmd_data == OP_ERS_VFY) begin
            nxt_mode = ST_ERS_CHECK;
            cap_ver  = 1'b1;
          end else begin
            nxt_mode = ST_READ;
          end
        end
        ST_PROGRAMMING: begin
          prg_stop = 1'b1;
          nxt_mode = (cmd_data == OP_PRG_VFY) ? ST_PRG_CHECK : ST_READ;
        end
        default: begin
          case (cmd_data)
            OP_RESET: begin
              if (rst_armed) nxt_mode  = ST_READ;
              else           nxt_armed = 1'b1;
            end
            OP_READ:  nxt_mode = ST_READ;
            OP_ERASE: nxt_mode = ST_ERS_ARM;
            OP_PROG:  nxt_mode = ST_PRG_ARM;
            OP_IDENT: nxt_mode = ST_IDENT;
            OP_ERS_VFY: begin
              if (mode == ST_ERS_CHECK) cap_ver  = 1'b1;
              else                      nxt_mode = ST_READ;
            end
            default:  nxt_mode = ST_READ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= ST_READ;
      rst_armed <= 1'b0;
      ver_addr  <= '0;
      prg_addr  <= '0;
      prg_data  <= '0;
    end else begin
      mode      <= nxt_mode;
      rst_armed <= nxt_armed;
      if (cap_ver) ver_addr <= lat_addr;
      if (cap_prg) begin
        prg_addr <= lat_addr;
        prg_data <= cmd_data;
      end
    end
  end

  // Stop timers, one per pulse type
  flash_stop_timer #(.LIMIT(ERASE_TICKS)) u_ers_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (ers_start),
    .stop   (ers_stop | ~hv_on),
    .active (erase_pulse),
    .fin    (ers_fin),
    .tmo    (erase_tmo)
  );

  flash_stop_timer #(.LIMIT(PROG_TICKS)) u_prg_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (prg_start),
    .stop   (prg_stop | ~hv_on),
    .active (prog_pulse),
    .fin    (prg_fin),
    .tmo    (prog_tmo)
  );

  // A pulse changes the array only when it ends with the voltage present.
  assign erase_all = ers_fin & hv_on;
  assign prog_en   = prg_fin & hv_on;

  flash_cell_model #(.ADDR_W(ADDR_W)) u_cells (
    .clk       (clk),
    .rst_n     (rst_n),
    .erase_all (erase_all),
    .prog_en   (prog_en),
    .prog_addr (prg_addr),
    .prog_data (prg_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
  );

  // Read path
  assign view_mode = hv_on ? mode : ST_READ;
  assign id_view   = hv_on ? (mode == ST_IDENT) : id_sel;

  always_comb begin
    case (view_mode)
      ST_ERS_CHECK: rd_addr = ver_addr;
      ST_PRG_CHECK: rd_addr = prg_addr;
      default:      rd_addr = addr;
    endcase
  end

  assign dq_out = id_view ? ident_byte(addr[0], MFG_ID, DEV_ID) : rd_data;
  assign dq_oe  = ~ce_n & ~oe_n & we_n;

  // Assertions
  assert_hv_lockout_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hv_on |=> (!erase_pulse && !prog_pulse && mode == ST_READ));

  assert_erase_two_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_pulse) |-> $past(mode == ST_ERS_ARM));

  assert_prog_two_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_pulse) |-> $past(mode == ST_PRG_ARM));

  assert_erase_verify_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_on && cmd_vld && mode == ST_ERASING) |=> !erase_pulse);

  assert_prog_verify_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_on && cmd_vld && mode == ST_PROGRAMMING) |=> !prog_pulse);

  assert_single_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(erase_pulse && prog_pulse));

endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;

  localparam int         AW    = 6;
  localparam int         DEPTH = 64;
  localparam int         ETCK  = 200;
  localparam logic [7:0] MFG   = 8'h01;
  localparam logic [7:0] DEV   = 8'hA1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic          hv_on = 1'b0, id_sel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    dq_in = '0;
  logic [7:0]    dq_out;
  logic          dq_oe, erase_pulse, prog_pulse, erase_tmo, prog_tmo;

  flash_cmd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .hv_on(hv_on), .id_sel(id_sel), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .erase_pulse(erase_pulse),
    .prog_pulse(prog_pulse), .erase_tmo(erase_tmo), .prog_tmo(prog_tmo)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int ers_rise = 0, prg_rise = 0, ers_tmo_n = 0, prg_tmo_n = 0, overlap = 0;
  logic ep_q = 1'b0, pp_q = 1'b0;
  logic [7:0] ref_mem [DEPTH];

  always @(negedge clk) begin
    if (rst_n) begin
      if (erase_pulse && !ep_q) ers_rise++;
      if (prog_pulse && !pp_q) prg_rise++;
      if (erase_tmo) ers_tmo_n++;
      if (prog_tmo) prg_tmo_n++;
      if (erase_pulse && prog_pulse) overlap++;
      ep_q <= erase_pulse;
      pp_q <= prog_pulse;
    end
  end

  // Bit clearing written as De Morgan form of the requirement.
  function automatic logic [7:0] cleared(input logic [7:0] o, input logic [7:0] n);
    return ~(~o | ~n);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; dq_in = d; ce_n = 1'b0; we_n = 1'b0;
    repeat (4) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // we_n falls first, ce_n falls later; we_n rises first, ce_n later.
  task automatic wr_split(input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                          input logic [AW-1:0] a2, input logic [7:0] d0,
                          input logic [7:0] d1);
    @(negedge clk);
    addr = a0; dq_in = d0; we_n = 1'b0;
    repeat (5) @(negedge clk);
    addr = a1; ce_n = 1'b0;
    repeat (5) @(negedge clk);
    addr = a2;
    repeat (2) @(negedge clk);
    we_n = 1'b1;
    repeat (5) @(negedge clk);
    dq_in = d1;
    repeat (2) @(negedge clk);
    ce_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    #1 v = dq_out;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic pick_junk(output logic [7:0] j);
    do j = 8'($urandom);
    while (j inside {8'h00, 8'h20, 8'h40, 8'h90, 8'hA0, 8'hC0, 8'hFF});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v, d, j;
    int b0, b1;
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5 power-up state
    chk("R5 erase_pulse", 8'(erase_pulse), 8'h0);
    chk("R5 prog_pulse", 8'(prog_pulse), 8'h0);
    rd(5, v); chk("R5 erased read", v, 8'hFF);

    // R1 read-only operation without high voltage
    wr(3, 8'h40); wr(3, 8'hAA);
    chk("R1 no pulse", 8'(prg_rise), 8'h0);
    rd(3, v); chk("R1 array untouched", v, 8'hFF);
    id_sel = 1'b1;
    rd(0, v); chk("R1 id even", v, MFG);
    rd(1, v); chk("R1 id odd", v, DEV);
    id_sel = 1'b0;

    hv_on = 1'b1;
    repeat (2) @(negedge clk);

    // R2 / R7 program then verify
    wr(0, 8'h40); wr(3, 8'h5A);
    chk("R2 program pulse on", 8'(prog_pulse), 8'h1);
    wr(0, 8'hC0);
    chk("R7 pulse stopped", 8'(prog_pulse), 8'h0);
    rd(9, v); chk("R7 verify shows target", v, 8'h5A);
    ref_mem[3] = 8'h5A;
    wr(0, 8'h40); wr(3, 8'h0F); wr(0, 8'hC0);
    rd(9, v); chk("R7 bits only clear", v, cleared(8'h5A, 8'h0F));
    ref_mem[3] = cleared(8'h5A, 8'h0F);

    // R8 program stop timer
    wr(0, 8'h40); wr(10, 8'h33);
    repeat (30) @(negedge clk);
    chk("R8 program timeout pulse off", 8'(prog_pulse), 8'h0);
    chk("R8 program timeout strobe", 8'(prg_tmo_n), 8'h1);
    wr(0, 8'h00);
    rd(10, v); chk("R8 program applied", v, 8'h33);
    ref_mem[10] = 8'h33;

    // R3 / R4 split strobes
    wr(0, 8'h40);
    wr_split(20, 21, 22, 8'h81, 8'h18);
    wr(0, 8'hC0);
    rd(0, v); chk("R4 first-rise data", v, 8'h81);
    wr(0, 8'h00);
    rd(21, v); chk("R3 last-fall address", v, 8'h81);
    rd(20, v); chk("R3 early address unused", v, 8'hFF);
    rd(22, v); chk("R3 late address unused", v, 8'hFF);
    ref_mem[21] = 8'h81;

    // R9 / R10 identifier and double reset
    wr(0, 8'h90);
    rd(0, v); chk("R9 id even", v, MFG);
    rd(1, v); chk("R9 id odd", v, DEV);
    wr(0, 8'hFF);
    rd(3, v); chk("R10 single reset ignored", v, DEV);
    wr(0, 8'hFF);
    rd(3, v); chk("R10 double reset to read", v, ref_mem[3]);
    wr(0, 8'h90); wr(0, 8'h00);
    rd(3, v); chk("R9 read command", v, ref_mem[3]);

    // R11 mismatched second cycle and junk bytes
    b0 = ers_rise; b1 = prg_rise;
    wr(0, 8'h20); wr(0, 8'h55);
    chk("R11 no erase", 8'(ers_rise - b0), 8'h0);
    rd(3, v); chk("R11 read after mismatch", v, ref_mem[3]);
    wr(0, 8'h20); wr(0, 8'h40); wr(5, 8'h77);
    chk("R11 no program", 8'(prg_rise - b1), 8'h0);
    rd(5, v); chk("R11 array intact", v, 8'hFF);

    // R12 output enable
    @(negedge clk);
    dq_in = 8'h00; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    #1 chk("R12 oe with we low", 8'(dq_oe), 8'h0);
    repeat (4) @(negedge clk);
    we_n = 1'b1;
    #1 chk("R12 oe active", 8'(dq_oe), 8'h1);
    ce_n = 1'b1; oe_n = 1'b1;
    #1 chk("R12 oe idle", 8'(dq_oe), 8'h0);
    repeat (6) @(negedge clk);

    // R1 voltage loss during erase pulse
    wr(0, 8'h20); wr(0, 8'h20);
    chk("R2 erase pulse on", 8'(erase_pulse), 8'h1);
    hv_on = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 erase aborted", 8'(erase_pulse), 8'h0);
    rd(3, v); chk("R1 abort keeps data", v, ref_mem[3]);
    hv_on = 1'b1;
    repeat (2) @(negedge clk);

    // R1 voltage loss during program pulse
    wr(0, 8'h40); wr(21, 8'h00);
    hv_on = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 program aborted", 8'(prog_pulse), 8'h0);
    rd(21, v); chk("R1 abort keeps byte", v, ref_mem[21]);
    hv_on = 1'b1;
    repeat (2) @(negedge clk);

    // R6 erase ended by verify
    wr(0, 8'h20); wr(0, 8'h20);
    wr(7, 8'hA0);
    chk("R6 pulse stopped", 8'(erase_pulse), 8'h0);
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    rd(3, v); chk("R6 verify byte", v, 8'hFF);
    wr(0, 8'h00);
    rd(21, v); chk("R6 erased", v, 8'hFF);
    rd(10, v); chk("R6 erased", v, 8'hFF);

    // Random program traffic with junk commands (R7, R11)
    for (int k = 0; k < 24; k++) begin
      logic [AW-1:0] a, b;
      a = AW'($urandom); b = AW'($urandom); d = 8'($urandom);
      wr(0, 8'h40); wr(a, d); wr(0, 8'hC0);
      rd(b, v); chk("R7 random verify", v, cleared(ref_mem[a], d));
      ref_mem[a] = cleared(ref_mem[a], d);
      pick_junk(j);
      wr(a, j);
      rd(b, v); chk("R11 junk then read", v, ref_mem[b]);
    end

    // R8 erase stop timer
    b0 = ers_tmo_n;
    wr(0, 8'h20); wr(0, 8'h20);
    repeat (ETCK + 20) @(negedge clk);
    chk("R8 erase timeout pulse off", 8'(erase_pulse), 8'h0);
    chk("R8 erase timeout strobe", 8'(ers_tmo_n - b0), 8'h1);
    wr(0, 8'h00);
    for (int k = 0; k < 6; k++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      rd(a, v); chk("R8 erase applied", v, 8'hFF);
    end

    chk("R13 no pulse overlap", 8'(overlap), 8'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule